// File: doc/BRIEF.md
# Serial Control Register Port for a Video Serializer

This block is the control-side serial slave of a video serializer. A host reaches a small bank of registers over a four-wire serial link in mode 0: the clock idles low, the slave samples on the rising edge and changes its output on the falling edge. Every access is a pair of 16-bit words sent most significant bit first. The first word carries a read/write flag in its top bit and a 12-bit register address in its low bits. The second word carries the write data, or, for a read, the slave returns the register contents in that word.

The bank holds two writable registers: a 16-bit configuration word, where a host typically writes 0x300 to pick the SMPTE timing mode, and a format-override register that either pins the output standard or leaves the device in automatic detection. It also exposes a status word built from lock and detected-standard inputs, and four timing counters taken straight from input ports. The serial pins are oversampled in the system clock domain, so SCLK must be much slower than `clk`, at least eight system clocks per SCLK period. The status and counter inputs are taken to be synchronous to `clk`.

Top module: `sdi_ctl_spi_port`

## Requirements
- R1: Bits are taken on rising SCLK edges while chip select is low, most significant bit first, and each access is exactly one 16-bit command word followed by one 16-bit data word.
- R2: Command bit 15 = 1 selects a read and 0 selects a write. Bits 11:0 give the register address, and bits 14:12 are ignored.
- R3: Address 0x004 reads as a status word: bit 0 is horizontal lock, bit 1 is vertical lock, bit 2 is standard lock, bits 9:5 are the detected-standard code, and all other bits are 0.
- R4: Address 0x006 is the format-override register. A write stores data bits 5:0, and a read returns them with bits 15:6 as 0. Bit 5 drives `force_on` and bits 4:0 drive `force_code`. Writing 0 returns the device to automatic detection, with `force_on` low.
- R5: Address 0x000 is a 16-bit read/write configuration register that is presented on `cfg_word`.
- R6: Addresses 0x012, 0x013, 0x014 and 0x015 are read-only and return `lines_frame`, `words_line`, `words_active` and `lines_active` in that order.
- R7: Writes to read-only or unmapped addresses change no register, and reads of unmapped addresses return 0.
- R8: A write lands only when the 16th data bit is received. Raising chip select earlier discards the access and realigns the next access to bit 0 of a command word.
- R9: For a read, the register value is captured when the command word completes. It is then driven on `spi_miso` MSB first, with each bit changing on a falling SCLK edge, so bit 15 is valid before the first data-word rising edge.
- R10: `spi_miso` is held low while chip select is high.
- R11: After reset, `cfg_word` is 0 and the override register is 0, so `force_on` is low and `force_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, low when idle |
| lock_h | input | 1 | Horizontal lock status |
| lock_v | input | 1 | Vertical lock status |
| lock_std | input | 1 | Standard lock status |
| std_code | input | 5 | Detected-standard code |
| lines_frame | input | 16 | Lines-per-frame count |
| words_line | input | 16 | Words-per-line count |
| words_active | input | 16 | Words-per-active-line count |
| lines_active | input | 16 | Active-lines-per-frame count |
| cfg_word | output | 16 | Configuration register contents |
| force_on | output | 1 | Format override enabled |
| force_code | output | 5 | Forced standard code |

## Verification
If the bit counter drifts, every later access is misframed. The next read then returns shifted or wrong data on `spi_miso` within one transfer, and a write lands at the wrong address or not at all. The configuration and override outputs are compared against a behavioural model on every clock, so a write that is lost, lands early, or touches the wrong register shows within four system clocks of the final data bit. Aborted accesses are followed directly by a full read, so a counter that survives a chip-select release is exposed by that read.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 12;
  localparam int CODE_W = 5;
  localparam int FORCE_W = CODE_W + 1;

  localparam logic [ADDR_W-1:0] A_CFG    = 12'h000;
  localparam logic [ADDR_W-1:0] A_STATUS = 12'h004;
  localparam logic [ADDR_W-1:0] A_FORCE  = 12'h006;
  localparam logic [ADDR_W-1:0] A_LINES  = 12'h012;
  localparam logic [ADDR_W-1:0] A_WORDS  = 12'h013;
  localparam logic [ADDR_W-1:0] A_AWORDS = 12'h014;
  localparam logic [ADDR_W-1:0] A_ALINES = 12'h015;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              std_lk;
    logic              v_lk;
    logic              h_lk;
  } lock_stat_t;
endpackage

// File: rtl/srp_pin_sync.sv
module srp_pin_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/srp_shift_engine.sv
module srp_shift_engine #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_idle,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_bit,
  input  logic [WORD_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              miso_q
);
  localparam int CNT_W = $clog2(2 * WORD_W);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(2 * WORD_W - 1);
  localparam logic [CNT_W-1:0] DATA_FST  = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] rx_sh;
  logic [WORD_W-1:0] tx_sh;
  logic              is_rd;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_flag;

  assign rd_addr = {rx_sh[ADDR_W-2:0], mosi_bit};
  assign rd_flag = rx_sh[WORD_W-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      is_rd    <= 1'b0;
      addr_q   <= '0;
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      miso_q   <= 1'b0;
    end else begin
      wr_pulse <= 1'b0;
      if (cs_idle) begin
        cnt    <= '0;
        is_rd  <= 1'b0;
        miso_q <= 1'b0;
      end else begin
        if (sclk_rise) begin
          rx_sh <= {rx_sh[WORD_W-2:0], mosi_bit};
          cnt   <= (cnt == DATA_LAST) ? '0 : cnt + 1'b1;
          if (cnt == CMD_LAST) begin
            is_rd  <= rd_flag;
            addr_q <= rd_addr;
            tx_sh  <= rd_flag ? rd_data : '0;
          end
          if (cnt == DATA_LAST && !is_rd) begin
            wr_pulse <= 1'b1;
            wr_addr  <= addr_q;
            wr_data  <= {rx_sh[WORD_W-2:0], mosi_bit};
          end
        end
        if (sclk_fall) begin
          if (cnt >= DATA_FST && is_rd) begin
            miso_q <= tx_sh[WORD_W-1];
            tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
          end else begin
            miso_q <= 1'b0;
          end
        end
      end
    end
  end

  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse); // R8
  AST_WR_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> $past(!cs_idle)); // R8
  AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !miso_q); // R10
endmodule

// File: rtl/srp_reg_bank.sv
module srp_reg_bank
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  lock_stat_t        stat,
  input  logic [WORD_W-1:0] cnt_lines,
  input  logic [WORD_W-1:0] cnt_words,
  input  logic [WORD_W-1:0] cnt_awords,
  input  logic [WORD_W-1:0] cnt_alines,
  output logic [WORD_W-1:0] cfg_q,
  output logic [FORCE_W-1:0] force_q
);
  localparam int STAT_PAD = WORD_W - CODE_W - 5;

  logic [WORD_W-1:0] stat_word;
  assign stat_word = {{STAT_PAD{1'b0}}, stat.code, 2'b00,
                      stat.std_lk, stat.v_lk, stat.h_lk};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      force_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CFG)   cfg_q   <= wr_data;
      if (wr_addr == A_FORCE) force_q <= wr_data[FORCE_W-1:0];
    end
  end

  always_comb begin
    case (rd_addr)
      A_CFG:    rd_data = cfg_q;
      A_STATUS: rd_data = stat_word;
      A_FORCE:  rd_data = {{(WORD_W-FORCE_W){1'b0}}, force_q};
      A_LINES:  rd_data = cnt_lines;
      A_WORDS:  rd_data = cnt_words;
      A_AWORDS: rd_data = cnt_awords;
      A_ALINES: rd_data = cnt_alines;
      default:  rd_data = '0;
    endcase
  end

  AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != A_CFG && wr_addr != A_FORCE)
      |=> ($stable(cfg_q) && $stable(force_q))); // R7
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(cfg_q) && $stable(force_q))); // R8
endmodule

// File: rtl/sdi_ctl_spi_port.sv
module sdi_ctl_spi_port
  import srp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              lock_h,
  input  logic              lock_v,
  input  logic              lock_std,
  input  logic [CODE_W-1:0] std_code,
  input  logic [WORD_W-1:0] lines_frame,
  input  logic [WORD_W-1:0] words_line,
  input  logic [WORD_W-1:0] words_active,
  input  logic [WORD_W-1:0] lines_active,
  output logic [WORD_W-1:0] cfg_word,
  output logic              force_on,
  output logic [CODE_W-1:0] force_code
);
  logic [2:0]         pins_s;
  logic               cs_s, sclk_s, mosi_s, sclk_d;
  logic               rise, fall;
  logic [ADDR_W-1:0]  rd_addr, wr_addr;
  logic [WORD_W-1:0]  rd_data, wr_data;
  logic               wr_pulse;
  logic [FORCE_W-1:0] force_q;
  lock_stat_t         stat;

  srp_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, spi_sclk, spi_mosi}),
    .q(pins_s)
  );

  assign {cs_s, sclk_s, mosi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  srp_shift_engine #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst(rst),
    .cs_idle(cs_s), .sclk_rise(rise), .sclk_fall(fall), .mosi_bit(mosi_s),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
    .miso_q(spi_miso)
  );

  assign stat = '{code: std_code, std_lk: lock_std, v_lk: lock_v, h_lk: lock_h};

  srp_reg_bank u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .stat(stat),
    .cnt_lines(lines_frame), .cnt_words(words_line),
    .cnt_awords(words_active), .cnt_alines(lines_active),
    .cfg_q(cfg_word), .force_q(force_q)
  );

  assign force_on   = force_q[FORCE_W-1];
  assign force_code = force_q[CODE_W-1:0];

  AST_AUTO_CLEARS_CODE: assert property (@(posedge clk) disable iff (rst)
    (wr_pulse && wr_addr == A_FORCE && wr_data == '0)
      |=> (!force_on && force_code == '0)); // R4
endmodule

// File: tb/sdi_ctl_spi_port_tb_top.sv
module sdi_ctl_spi_port_tb_top;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic lk_h = 1'b0, lk_v = 1'b0, lk_s = 1'b0;
  logic [4:0]  code = '0;
  logic [15:0] c_lines = '0, c_words = '0, c_aw = '0, c_al = '0;
  logic [15:0] cfg_word;
  logic        force_on;
  logic [4:0]  force_code;

  int checks = 0, errors = 0;
  longint cyc = 0;
  int cs_hi = 0;

  logic [15:0] m_cfg = '0;
  logic [5:0]  m_force = '0;
  bit          pend = 0;
  longint      pend_at = 0;
  logic [11:0] pend_addr;
  logic [15:0] pend_data;

  always #4 clk = ~clk;

  sdi_ctl_spi_port dut_i (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .lock_h(lk_h), .lock_v(lk_v), .lock_std(lk_s),
    .std_code(code), .lines_frame(c_lines), .words_line(c_words),
    .words_active(c_aw), .lines_active(c_al), .cfg_word(cfg_word),
    .force_on(force_on), .force_code(force_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [11:0] a);
    case (a)
      12'h000: return m_cfg;
      12'h004: return {6'b0, code, 2'b00, lk_s, lk_v, lk_h};
      12'h006: return {10'b0, m_force};
      12'h012: return c_lines;
      12'h013: return c_words;
      12'h014: return c_aw;
      12'h015: return c_al;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    cs_hi <= cs_n ? cs_hi + 1 : 0;
  end

  // per-clock comparison with the behavioural model
  always @(negedge clk) begin
    if (pend && cyc >= pend_at) begin
      pend = 0;
      if (pend_addr == 12'h000) m_cfg = pend_data;
      if (pend_addr == 12'h006) m_force = pend_data[5:0];
    end
    if (!rst) begin
      chk("R5 cfg_word", {16'h0, cfg_word}, {16'h0, m_cfg});
      chk("R4 force", {26'h0, force_on, force_code}, {26'h0, m_force});
      if (cs_hi >= 4) chk("R10 miso idle", {31'h0, miso}, 32'h0);
    end
  end

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] aw, input logic [15:0] dw,
                      input int nbits, output logic [15:0] got);
    got = '0;
    cs_n = 1'b0;
    half();
    for (int b = 0; b < nbits; b++) begin
      mosi = (b < 16) ? aw[15-b] : dw[31-b];
      half();
      if (b >= 16) got[31-b] = miso;
      sclk = 1'b1;
      if (b == 31 && !aw[15]) begin
        pend = 1; pend_at = cyc + 4; pend_addr = aw[11:0]; pend_data = dw;
      end
      half();
      sclk = 1'b0;
    end
    half();
    cs_n = 1'b1;
    half(); half();
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    logic [15:0] g;
    xfer(a & 16'h7FFF, d, 32, g);
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a);
    logic [15:0] g;
    logic [15:0] e;
    e = model_read(a[11:0]);
    xfer(a | 16'h8000, 16'h0000, 32, g);
    chk(req, {16'h0, g}, {16'h0, e});
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] g;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11 cfg reset", {16'h0, cfg_word}, 32'h0);
    chk("R11 force reset", {26'h0, force_on, force_code}, 32'h0);
    chk("R10 miso reset", {31'h0, miso}, 32'h0);

    lk_h = 1; lk_v = 0; lk_s = 1; code = 5'h0B;
    c_lines = 16'd1125; c_words = 16'd2200; c_aw = 16'd1920; c_al = 16'd1080;

    // R1 R5: configuration write and read-back
    wr(16'h0000, 16'h0300);
    rd_chk("R5 cfg readback", 16'h0000);
    wr(16'h0000, 16'hA5C3);
    rd_chk("R1 R9 msb-first readback", 16'h0000);

    // R3: status in two patterns
    rd_chk("R3 status a", 16'h0004);
    lk_h = 0; lk_v = 1; lk_s = 0; code = 5'h14;
    rd_chk("R3 status b", 16'h0004);
    lk_h = 1; lk_v = 1; lk_s = 1; code = 5'h1F;
    rd_chk("R3 status c", 16'h0004);

    // R4: override register
    wr(16'h0006, 16'h002C);
    rd_chk("R4 force readback", 16'h0006);
    chk("R4 force_on", {31'h0, force_on}, 32'h1);
    wr(16'h0006, 16'hFFFF);
    rd_chk("R4 force upper bits zero", 16'h0006);
    wr(16'h0006, 16'h0000);
    chk("R4 auto after zero", {26'h0, force_on, force_code}, 32'h0);

    // R6: timing counters
    rd_chk("R6 lines", 16'h0012);
    rd_chk("R6 words", 16'h0013);
    rd_chk("R6 active words", 16'h0014);
    rd_chk("R6 active lines", 16'h0015);

    // R7: read-only and unmapped writes ignored, unmapped reads zero
    wr(16'h0006, 16'h0025);
    wr(16'h0004, 16'hFFFF);
    wr(16'h0013, 16'h1111);
    wr(16'h0100, 16'h2222);
    rd_chk("R7 cfg untouched", 16'h0000);
    rd_chk("R7 force untouched", 16'h0006);
    rd_chk("R7 counter still input", 16'h0013);
    rd_chk("R7 unmapped read", 16'h07FF);
    rd_chk("R7 unmapped read 2", 16'h0100);

    // R2: bits 14:12 ignored
    wr(16'h7000, 16'h1234);
    chk("R2 write ignores 14:12", {16'h0, cfg_word}, 32'h1234);
    rd_chk("R2 read ignores 14:12", 16'hF006);

    // R8: aborted accesses
    xfer(16'h0000, 16'hBEEF, 31, g);
    chk("R8 abort at bit 31", {16'h0, cfg_word}, 32'h1234);
    xfer(16'h0000, 16'hBEEF, 7, g);
    rd_chk("R8 realign after abort", 16'h0000);
    xfer(16'h0006, 16'h003F, 20, g);
    rd_chk("R8 force after abort", 16'h0006);

    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule